// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block evaluates one arithmetic or bitwise operation on two operands and reports the result together with six condition bits describing it: carry, overflow, sign, zero, auxiliary (nibble) carry and parity. An execution stage places the operands, an operation code and a width code on the inputs. It reads the result and the freshly computed condition bits in the same cycle. When it asserts the write enable, the condition bits are captured into a small status register on the next rising clock edge.

The operand width can be one byte, two bytes or four bytes. Operand bits above the chosen width have no effect, and the result is returned zero-extended. Carry-consuming operations take their incoming carry or borrow from the carry bit already held in the status register. This lets multi-word arithmetic be chained one operation at a time.

Parity always looks at the lowest result byte only. The nibble carry is always taken across the bit 3 / bit 4 boundary, whatever width is selected.

Top module: `stat_flag_unit`

## Requirements
- R1: `opcode` selects 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR and 7 (spare) AND. `size_sel` selects 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. Operand bits above the selected width are ignored. `result` carries the operation's value at that width, with every higher bit zero.
- R2: The carry bit (flag bit 0) is set when an addition carries out of the top bit of the selected width, or when a subtraction needs a borrow into it.
- R3: The overflow bit (flag bit 5) is set when the operands, read as two's-complement numbers at the selected width, give a signed result outside that width's range.
- R4: The sign bit (flag bit 4) equals the top bit of the result at the selected width.
- R5: The zero bit (flag bit 3) is set exactly when every result bit at the selected width is 0.
- R6: The auxiliary carry bit (flag bit 2) is set for arithmetic operations when a carry or borrow crosses from bit 3 into bit 4.
- R7: The parity bit (flag bit 1) is set when result bits 7..0 hold an even number of ones; bits above bit 7 do not affect it.
- R8: AND, OR and XOR (and code 7) clear the carry, overflow and auxiliary carry bits.
- R9: Add-with-carry adds the latched carry bit (`flags_q[0]`) as a carry-in. Subtract-with-borrow subtracts it as a borrow-in. Plain add and subtract ignore it.
- R10: `flags_q` loads `flags_now` on a rising clock edge when `flag_we` is 1 and holds otherwise. It clears to all zeros while `rst_n` is low. Both flag vectors use the bit order of R2 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | DATA_W | First operand (minuend for subtraction) |
| op_b | input | DATA_W | Second operand (subtrahend for subtraction) |
| opcode | input | 3 | Operation select, codes as in R1 |
| size_sel | input | 2 | Operand width select, codes as in R1 |
| flag_we | input | 1 | Capture `flags_now` into the status register |
| result | output | DATA_W | Zero-extended result at the selected width |
| flags_now | output | 6 | Condition bits of the current operation |
| flags_q | output | 6 | Latched status register |

## Verification
The bench builds the block with its default `DATA_W` of 32, so the byte, half-word and word widths are all reachable in one run. Each width then has its own carry-out position and sign bit, and the upper operand bytes carry values that must be ignored. Because vectors are applied back to back with the write enable high, each carry-consuming vector takes its carry from the vector before it. This exercises the chaining path with the latched carry both set and clear. Directed steps then cover the held register, the spare width code and a mid-run reset.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_SPR = 3'd7
  } sfu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } sfu_size_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic nib;
    logic par;
    logic cry;
  } sfu_flags_t;

  // number of active byte lanes for a width code
  function automatic int lanes_for(input logic [1:0] sz);
    case (sz)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // index of the sign bit for a width code
  function automatic int top_bit(input logic [1:0] sz);
    return lanes_for(sz) * 8 - 1;
  endfunction

  // true when a byte holds an even count of ones
  function automatic logic even_ones(input logic [7:0] b);
    return ~(^b);
  endfunction

  function automatic logic op_is_arith(input sfu_op_e op);
    return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) || (op == OP_SBB);
  endfunction

  function automatic logic op_is_sub(input sfu_op_e op);
    return (op == OP_SUB) || (op == OP_SBB);
  endfunction

  function automatic logic op_uses_carry(input sfu_op_e op);
    return (op == OP_ADC) || (op == OP_SBB);
  endfunction

endpackage

// File: rtl/sfu_operand_mask.sv
module sfu_operand_mask
  import sfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        size_sel,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] trimmed
);
  localparam int LANES = DATA_W / 8;

  logic [LANES-1:0] lane_en;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_en[g] = (g < lanes_for(size_sel));
    assign trimmed[g*8 +: 8] = raw[g*8 +: 8] & {8{lane_en[g]}};
  end
endmodule

// File: rtl/sfu_arith_core.sv
module sfu_arith_core
  import sfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  sfu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              carry_q,
  output logic [DATA_W:0]   wide,
  output logic              is_arith,
  output logic              is_sub
);
  logic              cin;
  logic [DATA_W:0]   a_x;
  logic [DATA_W:0]   b_x;
  logic [DATA_W:0]   c_x;

  always_comb begin
    is_arith = op_is_arith(op);
    is_sub   = op_is_sub(op);
    cin      = op_uses_carry(op) & carry_q;
    a_x      = {1'b0, a};
    b_x      = {1'b0, b};
    c_x      = {{DATA_W{1'b0}}, cin};
    case (op)
      OP_ADD, OP_ADC: wide = a_x + b_x + c_x;
      OP_SUB, OP_SBB: wide = a_x - b_x - c_x;
      OP_OR:          wide = a_x | b_x;
      OP_XOR:         wide = a_x ^ b_x;
      default:        wide = a_x & b_x;
    endcase
  end
endmodule

// File: rtl/sfu_flag_eval.sv
module sfu_flag_eval
  import sfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        size_sel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W:0]   wide,
  input  logic [DATA_W-1:0] res,
  input  logic              is_arith,
  input  logic              is_sub,
  output logic              carry_out,
  output logic              signed_ovf,
  output logic              nibble_cy,
  output sfu_flags_t        flags
);
  localparam int IDX_W = $clog2(DATA_W + 1);

  logic [IDX_W-1:0] msb;
  logic             a_top;
  logic             b_top;
  logic             r_top;

  always_comb begin
    msb        = IDX_W'(top_bit(size_sel));
    carry_out  = wide[msb + 1'b1];
    a_top      = a[msb];
    b_top      = b[msb];
    r_top      = res[msb];
    signed_ovf = is_sub ? ((a_top != b_top) && (r_top != a_top))
                        : ((a_top == b_top) && (r_top != a_top));
    nibble_cy  = a[4] ^ b[4] ^ res[4];

    flags.cry  = is_arith & carry_out;
    flags.ovf  = is_arith & signed_ovf;
    flags.nib  = is_arith & nibble_cy;
    flags.sgn  = r_top;
    flags.zro  = (res == '0);
    flags.par  = even_ones(res[7:0]);
  end
endmodule

// File: rtl/sfu_flag_reg.sv
module sfu_flag_reg
  import sfu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  sfu_flags_t d,
  output sfu_flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/stat_flag_unit.sv
module stat_flag_unit
  import sfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [2:0]        opcode,
  input  logic [1:0]        size_sel,
  input  logic              flag_we,
  output logic [DATA_W-1:0] result,
  output logic [5:0]        flags_now,
  output logic [5:0]        flags_q
);
  sfu_op_e           op_w;
  logic [DATA_W-1:0] a_trim;
  logic [DATA_W-1:0] b_trim;
  logic [DATA_W:0]   wide_w;
  logic [DATA_W-1:0] res_w;
  logic              arith_w;
  logic              sub_w;
  logic              carry_out_w;
  logic              signed_ovf_w;
  logic              nibble_cy_w;
  sfu_flags_t        flags_d;
  sfu_flags_t        flags_r;

  assign op_w = sfu_op_e'(opcode);

  sfu_operand_mask #(.DATA_W(DATA_W)) u_mask_a (
    .size_sel (size_sel),
    .raw      (op_a),
    .trimmed  (a_trim)
  );

  sfu_operand_mask #(.DATA_W(DATA_W)) u_mask_b (
    .size_sel (size_sel),
    .raw      (op_b),
    .trimmed  (b_trim)
  );

  sfu_arith_core #(.DATA_W(DATA_W)) u_core (
    .op       (op_w),
    .a        (a_trim),
    .b        (b_trim),
    .carry_q  (flags_r.cry),
    .wide     (wide_w),
    .is_arith (arith_w),
    .is_sub   (sub_w)
  );

  sfu_operand_mask #(.DATA_W(DATA_W)) u_mask_r (
    .size_sel (size_sel),
    .raw      (wide_w[DATA_W-1:0]),
    .trimmed  (res_w)
  );

  sfu_flag_eval #(.DATA_W(DATA_W)) u_eval (
    .size_sel   (size_sel),
    .a          (a_trim),
    .b          (b_trim),
    .wide       (wide_w),
    .res        (res_w),
    .is_arith   (arith_w),
    .is_sub     (sub_w),
    .carry_out  (carry_out_w),
    .signed_ovf (signed_ovf_w),
    .nibble_cy  (nibble_cy_w),
    .flags      (flags_d)
  );

  sfu_flag_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (flag_we),
    .d     (flags_d),
    .q     (flags_r)
  );

  assign result    = res_w;
  assign flags_now = flags_d;
  assign flags_q   = flags_r;
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [2:0]        opcode,
  input logic [1:0]        size_sel,
  input logic              flag_we,
  input logic [DATA_W-1:0] result,
  input logic [5:0]        flags_now,
  input logic [5:0]        flags_q
);
  assert_byte_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (size_sel == 2'd0) |-> (result[DATA_W-1:8] == '0));

  assert_word_add_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 3'd0 && size_sel == 2'd2) |-> (flags_now[0] == (result < op_a)));

  assert_zero_not_negative_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flags_now[3] |-> !flags_now[4]);

  assert_logic_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode >= 3'd4) |-> (!flags_now[0] && !flags_now[5] && !flags_now[2]));

  assert_chain_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 3'd1 && size_sel == 2'd2) |->
      (result == op_a + op_b + {{(DATA_W-1){1'b0}}, flags_q[0]}));

  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (flags_q == $past(flags_now)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags_q));

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rst_n |=> (flags_q == 6'd0));
endmodule

bind stat_flag_unit sfu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_a      (op_a),
  .op_b      (op_b),
  .opcode    (opcode),
  .size_sel  (size_sel),
  .flag_we   (flag_we),
  .result    (result),
  .flags_now (flags_now),
  .flags_q   (flags_q)
);

// File: tb/sim_stat_flag_unit.sv
`timescale 1ns/1ps
module sim_stat_flag_unit;
  localparam int DW = 32;
  localparam int NV = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] op_a = '0;
  logic [DW-1:0] op_b = '0;
  logic [2:0]    opcode = '0;
  logic [1:0]    size_sel = '0;
  logic          flag_we = 1'b0;
  logic [DW-1:0] result;
  logic [5:0]    flags_now;
  logic [5:0]    flags_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stat_flag_unit #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opcode(opcode),
    .size_sel(size_sel), .flag_we(flag_we), .result(result),
    .flags_now(flags_now), .flags_q(flags_q)
  );

  // {opcode, size, a, b, expected result, expected flags {ovf,sgn,zro,nib,par,cry}}
  localparam logic [106:0] VEC [NV] = '{
    {3'd0, 2'd0, 32'h0000007F, 32'h00000001, 32'h00000080, 6'h34},
    {3'd0, 2'd0, 32'h000000FF, 32'h00000001, 32'h00000000, 6'h0F},
    {3'd1, 2'd0, 32'h00000010, 32'h00000020, 32'h00000031, 6'h00},
    {3'd2, 2'd1, 32'h00000000, 32'h00000001, 32'h0000FFFF, 6'h17},
    {3'd3, 2'd1, 32'h00008000, 32'h00000000, 32'h00007FFF, 6'h26},
    {3'd0, 2'd2, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 6'h0F},
    {3'd4, 2'd2, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 6'h12},
    {3'd5, 2'd0, 32'h12345601, 32'hABCDEF02, 32'h00000003, 6'h02},
    {3'd6, 2'd1, 32'hFFFFAAAA, 32'h0000AAAA, 32'h00000000, 6'h0A},
    {3'd2, 2'd2, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 6'h26},
    {3'd0, 2'd1, 32'hDEAD8000, 32'hBEEF8000, 32'h00000000, 6'h2B},
    {3'd3, 2'd0, 32'h00000000, 32'h00000000, 32'h000000FF, 6'h17},
    {3'd1, 2'd2, 32'h7FFFFFFF, 32'h00000000, 32'h80000000, 6'h36},
    {3'd2, 2'd0, 32'h00000010, 32'h00000001, 32'h0000000F, 6'h06}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] b, input logic we);
    @(negedge clk);
    opcode = op; size_sel = sz; op_a = a; op_b = b; flag_we = we;
    #1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(flags_q == 6'h00, "R10 reset", {26'd0, flags_q}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [2:0]  v_op;
      logic [1:0]  v_sz;
      logic [31:0] v_a, v_b, v_r;
      logic [5:0]  v_f;
      string       ftag;
      {v_op, v_sz, v_a, v_b, v_r, v_f} = VEC[i];
      apply(v_op, v_sz, v_a, v_b, 1'b1);
      check(result == v_r, (v_op == 3'd1 || v_op == 3'd3) ? "R9 result" : "R1 result", result, v_r);
      ftag = (v_op >= 3'd4) ? "R8 carry" : "R2 carry";
      check(flags_now[0] == v_f[0], ftag, {31'd0, flags_now[0]}, {31'd0, v_f[0]});
      ftag = (v_op >= 3'd4) ? "R8 overflow" : "R3 overflow";
      check(flags_now[5] == v_f[5], ftag, {31'd0, flags_now[5]}, {31'd0, v_f[5]});
      check(flags_now[4] == v_f[4], "R4 sign", {31'd0, flags_now[4]}, {31'd0, v_f[4]});
      check(flags_now[3] == v_f[3], "R5 zero", {31'd0, flags_now[3]}, {31'd0, v_f[3]});
      ftag = (v_op >= 3'd4) ? "R8 aux" : "R6 aux";
      check(flags_now[2] == v_f[2], ftag, {31'd0, flags_now[2]}, {31'd0, v_f[2]});
      check(flags_now[1] == v_f[1], "R7 parity", {31'd0, flags_now[1]}, {31'd0, v_f[1]});
      @(posedge clk);
      #1;
      check(flags_q == v_f, "R10 load", {26'd0, flags_q}, {26'd0, v_f});
    end

    // R10 hold: write enable low, register keeps 0x06 from last vector
    apply(3'd0, 2'd0, 32'h000000FF, 32'h00000001, 1'b0);
    check(flags_now == 6'h0F, "R2 carry byte", {26'd0, flags_now}, 32'h0F);
    @(posedge clk);
    #1;
    check(flags_q == 6'h06, "R10 hold", {26'd0, flags_q}, 32'h06);

    // R9 with latched carry clear
    apply(3'd1, 2'd0, 32'h00000010, 32'h00000020, 1'b0);
    check(result == 32'h30, "R9 no carry in", result, 32'h30);

    // set carry, then chain
    apply(3'd0, 2'd0, 32'h000000FF, 32'h00000001, 1'b1);
    @(posedge clk);
    #1;
    check(flags_q == 6'h0F, "R10 load carry", {26'd0, flags_q}, 32'h0F);
    apply(3'd1, 2'd0, 32'h00000010, 32'h00000020, 1'b0);
    check(result == 32'h31, "R9 carry in", result, 32'h31);
    apply(3'd0, 2'd0, 32'h00000010, 32'h00000020, 1'b0);
    check(result == 32'h30, "R9 plain add ignores carry", result, 32'h30);

    // R1: spare width code 3 acts as 32 bits, spare opcode 7 acts as AND
    apply(3'd0, 2'd3, 32'h00010000, 32'h0000FFFF, 1'b0);
    check(result == 32'h0001FFFF, "R1 width code 3", result, 32'h0001FFFF);
    apply(3'd7, 2'd2, 32'h0F0F00FF, 32'h00FF0F0F, 1'b0);
    check(result == 32'h000F000F, "R1 spare opcode", result, 32'h000F000F);

    // R7: high bytes do not touch parity
    apply(3'd5, 2'd2, 32'h01000000, 32'h00000003, 1'b0);
    check(flags_now[1] == 1'b1, "R7 upper bytes", {31'd0, flags_now[1]}, 32'h1);

    // R10 mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(flags_q == 6'h00, "R10 async clear", {26'd0, flags_q}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule